// File: doc/BRIEF.md
# Serial Shift-and-Store Output Register

This block takes a serial bit stream into a chain of shift stages, one stage per rising clock edge. A second rank of storage latches lets software or a controller load a new word into the chain while the outputs keep showing the previous word. A strobe input decides when the parallel word updates. While the strobe is high, each storage latch is transparent and follows its shift stage. While the strobe is low, the latches hold. The parallel outputs are modelled as a data bit plus a drive-enable bit for each stage. An output-enable input switches every drive enable together.

Two serial cascade outputs let several blocks be chained into a longer register. The first is the last shift stage itself, so it changes on the rising edge. The second re-captures that same bit on the following falling edge. A downstream block clocked by the same clock therefore gets half a cycle of hold margin even when the clock edges are slow. A synchronous reset clears the shift stages and the cascade outputs. The storage latches clear for as long as reset is high.

Top module: `shift_store_reg`

## Requirements
- R1: On each rising clock edge, stage 0 takes `ser_in` and stage k takes the value that stage k-1 held before the edge. Stage k appears on bit k of `par_data`.
- R2: While `strobe` is high, `par_data` follows the shift stages, so a rising edge with the strobe high moves new serial data straight to the parallel outputs.
- R3: While `strobe` is low, `par_data` holds the word present when the strobe fell, no matter how many edges shift the chain.
- R4: Every bit of `par_oe` equals `out_en`. `par_data` keeps the latch contents whatever `out_en` is.
- R5: `out_en` has no effect on shifting or on either cascade output. Data shifted while it is low is present once it returns high.
- R6: `casc_rise` is the last shift stage. After a rising edge it equals the value the next-to-last stage held before that edge.
- R7: `casc_fall` takes the value of `casc_rise` on each falling clock edge and does not change on a rising edge.
- R8: With `rst` high at a rising edge, all shift stages and `casc_rise` become 0. `casc_fall` becomes 0 at the next falling edge. `par_data` reads 0 while `rst` is high.
- R9: Two instances chained by feeding `casc_fall` of the first into `ser_in` of the second form a 16-stage register. A 16-bit pattern shifted in MSB first shows as {second `par_data`, first `par_data`} after 16 edges and a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; rising edge shifts, falling edge feeds `casc_fall` |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | High: storage latches transparent; low: hold |
| out_en | input | 1 | Drives all bits of `par_oe` |
| par_data | output | STAGES | Storage latch contents |
| par_oe | output | STAGES | Per-bit drive enable of the parallel outputs |
| casc_rise | output | 1 | Last shift stage, changes on the rising edge |
| casc_fall | output | 1 | Last shift stage, re-captured on the falling edge |

## Verification
A shift stage holding a wrong bit shows on `par_data` in the same cycle when the strobe is high. When the strobe is low, it shows at the next strobe. The same bit reaches `casc_rise` after at most STAGES-1 further edges, and `casc_fall` half a cycle after that. A latch that leaks while the strobe is low changes `par_data` right after the next rising edge. A falling-edge capture on the wrong edge shows as `casc_fall` leading instead of lagging `casc_rise` at the sample taken just after a rising edge. In the chained pair this also corrupts the second word by one bit position.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int unsigned DEF_STAGES = 8;

    // Level that makes the storage rank transparent
    localparam logic STROBE_OPEN = 1'b1;

    function automatic logic [DEF_STAGES-1:0] fill_bits(input logic b);
        fill_bits = {DEF_STAGES{b}};
    endfunction
endpackage

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
    parameter int unsigned STAGES = ssr_pkg::DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    output logic [STAGES-1:0] stage_q,
    output logic              tap_last
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] stages;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (rst) begin
            chain_d.stages = '0;
        end else begin
            chain_d.stages = {chain_q.stages[LAST-1:0], ser_in};
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign stage_q  = chain_q.stages;
    assign tap_last = chain_q.stages[LAST];
endmodule

// File: rtl/ssr_store_bank.sv
module ssr_store_bank #(
    parameter int unsigned STAGES = ssr_pkg::DEF_STAGES
) (
    input  logic              rst,
    input  logic              strobe,
    input  logic [STAGES-1:0] stage_q,
    output logic [STAGES-1:0] store_q
);
    logic [STAGES-1:0] store_d;
    logic              open_d;

    always_comb begin
        open_d  = rst || (strobe == ssr_pkg::STROBE_OPEN);
        store_d = rst ? '0 : stage_q;
    end

    // One level-sensitive storage latch per stage
    for (genvar g = 0; g < STAGES; g++) begin : g_latch
        always_latch begin
            if (open_d) begin
                store_q[g] = store_d[g];
            end
        end
    end
endmodule

// File: rtl/ssr_fall_capture.sv
module ssr_fall_capture (
    input  logic clk,
    input  logic rst,
    input  logic tap_in,
    output logic tap_fall
);
    typedef struct packed {
        logic bit_v;
    } fall_t;

    fall_t fall_d, fall_q;

    always_comb begin
        fall_d       = fall_q;
        fall_d.bit_v = rst ? 1'b0 : tap_in;
    end

    always_ff @(negedge clk) begin
        fall_q <= fall_d;
    end

    assign tap_fall = fall_q.bit_v;
endmodule

// File: rtl/ssr_out_drive.sv
module ssr_out_drive #(
    parameter int unsigned STAGES = ssr_pkg::DEF_STAGES
) (
    input  logic              out_en,
    input  logic [STAGES-1:0] store_q,
    output logic [STAGES-1:0] par_data,
    output logic [STAGES-1:0] par_oe
);
    for (genvar g = 0; g < STAGES; g++) begin : g_pin
        assign par_data[g] = store_q[g];
        assign par_oe[g]   = out_en;
    end
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg #(
    parameter int unsigned STAGES = ssr_pkg::DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              strobe,
    input  logic              out_en,
    output logic [STAGES-1:0] par_data,
    output logic [STAGES-1:0] par_oe,
    output logic              casc_rise,
    output logic              casc_fall
);
    logic [STAGES-1:0] stage_vec;
    logic [STAGES-1:0] store_vec;
    logic              tap_last;

    ssr_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .stage_q  (stage_vec),
        .tap_last (tap_last)
    );

    ssr_store_bank #(.STAGES(STAGES)) u_store (
        .rst     (rst),
        .strobe  (strobe),
        .stage_q (stage_vec),
        .store_q (store_vec)
    );

    ssr_fall_capture u_fall (
        .clk      (clk),
        .rst      (rst),
        .tap_in   (tap_last),
        .tap_fall (casc_fall)
    );

    ssr_out_drive #(.STAGES(STAGES)) u_drive (
        .out_en   (out_en),
        .store_q  (store_vec),
        .par_data (par_data),
        .par_oe   (par_oe)
    );

    assign casc_rise = tap_last;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
    parameter int unsigned STAGES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ser_in,
    input logic              strobe,
    input logic [STAGES-1:0] stage_q,
    input logic [STAGES-1:0] store,
    input logic              casc_rise,
    input logic              casc_fall
);
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stage_q == {$past(stage_q[STAGES-2:0]), $past(ser_in)})); // R1

    AST_RISE_TAP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (casc_rise == $past(stage_q[STAGES-2]))); // R6

    AST_STORE_FOLLOW: assert property (@(negedge clk) disable iff (rst)
        strobe |-> (store == stage_q)); // R2

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !$past(strobe) && !$past(rst)) |-> $stable(store)); // R3

    AST_FALL_CAPTURE: assert property (@(negedge clk) disable iff (rst)
        !$past(rst) |=> (casc_fall == $past(casc_rise))); // R7
endmodule

bind shift_store_reg ssr_checker #(.STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_in    (ser_in),
    .strobe    (strobe),
    .stage_q   (stage_vec),
    .store     (store_vec),
    .casc_rise (casc_rise),
    .casc_fall (casc_fall)
);

// File: tb/shift_store_reg_tb.sv
module shift_store_reg_tb;
    logic       clk = 1'b0;
    logic       rst, ser_in, strobe, out_en;
    logic [7:0] par_data, par_oe, par_data_b, par_oe_b;
    logic       casc_rise, casc_fall, rise_b, fall_b;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    shift_store_reg #(.STAGES(8)) u_dut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .strobe(strobe), .out_en(out_en),
        .par_data(par_data), .par_oe(par_oe), .casc_rise(casc_rise), .casc_fall(casc_fall)
    );

    // Second stage of a chain, fed from the falling-edge cascade output
    shift_store_reg #(.STAGES(8)) u_next (
        .clk(clk), .rst(rst), .ser_in(casc_fall), .strobe(strobe), .out_en(out_en),
        .par_data(par_data_b), .par_oe(par_oe_b), .casc_rise(rise_b), .casc_fall(fall_b)
    );

    // {ser_in, strobe, out_en, expected par_data, expected casc_rise}
    localparam logic [11:0] VEC [0:10] = '{
        {1'b1, 1'b1, 1'b1, 8'h01, 1'b0},
        {1'b0, 1'b1, 1'b1, 8'h02, 1'b0},
        {1'b1, 1'b1, 1'b1, 8'h05, 1'b0},
        {1'b1, 1'b0, 1'b1, 8'h05, 1'b0},
        {1'b0, 1'b0, 1'b0, 8'h05, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'h2D, 1'b0},
        {1'b0, 1'b1, 1'b1, 8'h5A, 1'b0},
        {1'b1, 1'b1, 1'b1, 8'hB5, 1'b1},
        {1'b0, 1'b1, 1'b1, 8'h6A, 1'b0},
        {1'b0, 1'b0, 1'b1, 8'h6A, 1'b1},
        {1'b0, 1'b1, 1'b1, 8'hA8, 1'b1}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic       prev_casc;
        logic [15:0] pat;
        rst = 1'b1; ser_in = 1'b0; strobe = 1'b1; out_en = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        // R8: reset state
        check("R8 par_data", {8'h0, par_data}, 16'h0000);
        check("R8 casc", {14'h0, casc_rise, casc_fall}, 16'h0000);
        check("R4 par_oe", {8'h0, par_oe}, 16'h00FF);
        rst = 1'b0;

        prev_casc = 1'b0;
        foreach (VEC[i]) begin
            ser_in = VEC[i][11];
            strobe = VEC[i][10];
            out_en = VEC[i][9];
            @(posedge clk);
            #5;
            // R1 R2 R3 R5: latch contents after this edge
            check($sformatf("R1/R2/R3/R5 row%0d par_data", i), {8'h0, par_data}, {8'h0, VEC[i][8:1]});
            check($sformatf("R4 row%0d par_oe", i), {8'h0, par_oe}, {8'h0, {8{VEC[i][9]}}});
            check($sformatf("R6 row%0d casc_rise", i), {15'h0, casc_rise}, {15'h0, VEC[i][0]});
            check($sformatf("R7 row%0d casc_fall before fall edge", i), {15'h0, casc_fall}, {15'h0, prev_casc});
            prev_casc = VEC[i][0];
        end
        @(negedge clk);
        #1;
        check("R7 casc_fall after fall edge", {15'h0, casc_fall}, {15'h0, prev_casc});

        // R8: synchronous clear from a non-zero state
        @(posedge clk);
        #5;
        rst = 1'b1;
        @(posedge clk);
        #5;
        check("R8 clear par_data", {8'h0, par_data}, 16'h0000);
        check("R8 clear casc_rise", {15'h0, casc_rise}, 16'h0000);
        @(negedge clk);
        #1;
        check("R8 clear casc_fall", {15'h0, casc_fall}, 16'h0000);

        // R9: two chained instances, strobe low during the load
        @(posedge clk);
        #5;
        rst = 1'b0;
        strobe = 1'b0;
        out_en = 1'b1;
        pat = 16'hA5C3;
        for (int k = 0; k < 16; k++) begin
            ser_in = pat[15-k];
            @(posedge clk);
            #5;
        end
        check("R3 chain held while strobe low", {par_data_b, par_data}, 16'h0000);
        strobe = 1'b1;
        #1;
        check("R9 chained word", {par_data_b, par_data}, pat);
        check("R4 chained par_oe", {par_oe_b, par_oe}, 16'hFFFF);

        done = 1'b1;
        finish_run();
    end
endmodule